// File: doc/BRIEF.md
# Flash Query and Status Read Formatter

This block builds the read word that a bank of identical parallel flash devices returns while it is in status, identifier or query mode. A bank is `BANK_W` bytes wide and is made of `BANK_W/DEV_W` devices, each used `DEV_W` bytes wide. A device may be able to run wider (`DEV_MAX_W`) than the width it is wired for. The formatter turns the bus byte offset into the index that each device decodes natively. It then looks up that device's answer and copies the answer across every device in the bank. When the access is wider than the bank, it packs several bank answers side by side. Array reads and command decoding are done elsewhere. The current mode, the status byte and the two identifier codes arrive as inputs, and the query table contents are a parameter.

A read is requested by pulsing `rd_en` for one clock with the address, size and mode. The formatted word and a valid flag come out of registers on the next clock. The data stays unchanged until the next read.

Top module: `flash_query_fmt`

## Requirements
- R1: `rd_valid` is high in exactly the cycle after a cycle in which `rd_en` was high, and the new `rd_data` appears in that same cycle.
- R2: While `rd_en` is low, `rd_data` keeps its last value whatever the other inputs do.
- R3: Each device decodes the index `addr >> (log2(BANK_W) + log2(DEV_MAX_W) - log2(DEV_W))`. Address bits shifted out have no effect.
- R4: The query table has 82 entries. By default, entries 0x10, 0x11, 0x12 and 0x13 hold 0x51, 0x52, 0x59 and 0x01, entry 0x50 holds 0x00 and entry 0x51 holds 0xA5. A query index of 82 or more returns zero.
- R5: For a device used narrower than its maximum width, only byte mode (`DEV_W`=1) answers, and the query byte fills the device's lane. Any other narrow setup answers zero.
- R6: The answer of one device, zero-extended to `DEV_W` bytes, is repeated in each `DEV_W`-byte slice of the bank.
- R7: In identifier mode, only the low 8 bits of the index are decoded. Index 0 gives `mfr_code`, index 1 gives `dev_code`, and every other index gives zero. Codes are truncated or zero-extended to `DEV_W` bytes.
- R8: If the access is wider than the bank, bank slice k of the result is the answer for address `addr + k*BANK_W`, with slice 0 in the low lanes.
- R9: In status mode, the status byte sits in the low byte of each `DEV_W` slice that fits wholly in the access. Slice 0 always carries it, and all other bytes are zero.
- R10: `rd_size` codes are 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. Bytes above the access width read as zero. `rd_mode` codes are 0 for status, 1 for identifier, 2 for query and 3 for idle, and idle returns zero.
- R11: After reset, `rd_valid` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Bus byte offset |
| rd_size | input | 2 | Access width code |
| rd_mode | input | 2 | Current read mode code |
| status_byte | input | 8 | Status byte of one device |
| mfr_code | input | 16 | Manufacturer identifier |
| dev_code | input | 16 | Device identifier |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | DATA_BYTES*8 | Formatted read data |

## Verification
A wrong shift amount shows up in the very next read as a neighbouring table entry, or as zero where a "QRY" byte was expected. A slip in the replication or packing logic shows as lanes that differ from their neighbours, or as lanes that are empty when they should be filled. Because the output register updates only on a strobe, a bad enable shows up immediately as data that changes during idle cycles or as a missing valid pulse. Four bank geometries are exercised: byte mode, a native single-byte device, native 16-bit devices, and an unsupported narrow setup.

// File: rtl/flash_qf_pkg.sv
package flash_qf_pkg;
  localparam int QT_LEN = 82;
  localparam int QT_IW  = 7;

  typedef logic [7:0] qtab_t [QT_LEN];

  typedef enum logic [1:0] {
    MODE_STATUS = 2'd0,
    MODE_IDENT  = 2'd1,
    MODE_QUERY  = 2'd2,
    MODE_IDLE   = 2'd3
  } fmt_mode_e;

  // Default query table: identification string plus a few fixed fields.
  function automatic qtab_t default_qtab();
    qtab_t t;
    for (int i = 0; i < QT_LEN; i++) t[i] = 8'h00;
    t[16] = 8'h51;
    t[17] = 8'h52;
    t[18] = 8'h59;
    t[19] = 8'h01;
    t[21] = 8'h31;
    t[27] = 8'h45;
    t[28] = 8'h55;
    t[44] = 8'h01;
    t[81] = 8'hA5;
    return t;
  endfunction

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/flash_qf_slice.sv
module flash_qf_slice #(
  parameter int ADDR_W    = 16,
  parameter int BANK_W    = 4,
  parameter int DEV_W     = 1,
  parameter int DEV_MAX_W = 2,
  parameter flash_qf_pkg::qtab_t QTAB = flash_qf_pkg::default_qtab()
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          mode_i,
  input  logic [15:0]         mfr_i,
  input  logic [15:0]         dev_i,
  output logic [BANK_W*8-1:0] resp_o
);
  import flash_qf_pkg::*;

  localparam int SHIFT = $clog2(BANK_W) + $clog2(DEV_MAX_W) - $clog2(DEV_W);
  localparam int DW    = DEV_W * 8;
  localparam int NDEV  = BANK_W / DEV_W;

  logic [ADDR_W-1:0] idx;
  logic              in_tab;
  logic [7:0]        qbyte;
  logic [DW-1:0]     qdev;
  logic [31:0]       code;
  logic [DW-1:0]     idev;
  logic [DW-1:0]     devr;

  assign idx    = addr_i >> SHIFT;
  assign in_tab = idx < ADDR_W'(QT_LEN);

  always_comb qbyte = in_tab ? QTAB[idx[QT_IW-1:0]] : 8'h00;

  // Device answer variant chosen by how the device is wired.
  generate
    if (DEV_W == DEV_MAX_W) begin : g_native
      assign qdev = DW'(qbyte);
    end else if (DEV_W == 1) begin : g_bytemode
      assign qdev = {DEV_W{qbyte}};
    end else begin : g_unsupported
      assign qdev = '0;
    end
  endgenerate

  always_comb begin
    case (idx[7:0])
      8'd0:    code = {16'h0000, mfr_i};
      8'd1:    code = {16'h0000, dev_i};
      default: code = 32'h0;
    endcase
  end
  assign idev = code[DW-1:0];

  generate
    if (DW < 32) begin : g_trim
      logic unused_code_hi;
      assign unused_code_hi = ^code[31:DW];
    end
  endgenerate

  always_comb begin
    case (mode_i)
      MODE_QUERY: devr = qdev;
      MODE_IDENT: devr = idev;
      default:    devr = '0;
    endcase
  end

  assign resp_o = {NDEV{devr}};

  // Guards next to the lookup.
  always_comb begin
    if (mode_i == MODE_QUERY && !in_tab)
      assert_beyond_table_R4: assert (resp_o == '0);
    if (mode_i == MODE_IDENT && idx[7:1] != 7'd0)
      assert_ident_other_R7: assert (resp_o == '0);
  end
endmodule

// File: rtl/flash_qf_status.sv
module flash_qf_status #(
  parameter int DATA_BYTES = 4,
  parameter int DEV_W      = 1
) (
  input  logic [7:0]              status_i,
  input  logic [2:0]              nbytes_i,
  output logic [DATA_BYTES*8-1:0] stat_o
);
  generate
    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
      if (b == 0) begin : g_first
        assign stat_o[7:0] = status_i;
      end else if ((b % DEV_W) == 0) begin : g_head
        assign stat_o[b*8 +: 8] =
          ({29'd0, nbytes_i} >= 32'(b + DEV_W)) ? status_i : 8'h00;
      end else begin : g_pad
        assign stat_o[b*8 +: 8] = 8'h00;
      end
    end
  endgenerate
endmodule

// File: rtl/flash_query_fmt.sv
module flash_query_fmt #(
  parameter int ADDR_W     = 16,
  parameter int DATA_BYTES = 4,
  parameter int BANK_W     = 4,
  parameter int DEV_W      = 1,
  parameter int DEV_MAX_W  = 2,
  parameter flash_qf_pkg::qtab_t QTAB = flash_qf_pkg::default_qtab()
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [1:0]              rd_size,
  input  logic [1:0]              rd_mode,
  input  logic [7:0]              status_byte,
  input  logic [15:0]             mfr_code,
  input  logic [15:0]             dev_code,
  output logic                    rd_valid,
  output logic [DATA_BYTES*8-1:0] rd_data
);
  import flash_qf_pkg::*;

  localparam int NSLICE = DATA_BYTES / BANK_W;
  localparam int DW     = DATA_BYTES * 8;
  localparam int BW     = BANK_W * 8;

  logic [2:0]    nbytes;
  logic [DW-1:0] packed_resp;
  logic [DW-1:0] stat_word;
  logic [DW-1:0] lane_mask;
  logic [DW-1:0] next_data;

  assign nbytes = size_bytes(rd_size);

  // One lookup per bank slice; slice k answers for the k-th bank address.
  generate
    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
      flash_qf_slice #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DEV_W(DEV_W),
        .DEV_MAX_W(DEV_MAX_W), .QTAB(QTAB)
      ) u_slice (
        .addr_i (rd_addr + ADDR_W'(k * BANK_W)),
        .mode_i (rd_mode),
        .mfr_i  (mfr_code),
        .dev_i  (dev_code),
        .resp_o (packed_resp[k*BW +: BW])
      );
    end

    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_mask
      assign lane_mask[b*8 +: 8] = {8{(32'(b) < {29'd0, nbytes})}};
    end
  endgenerate

  flash_qf_status #(.DATA_BYTES(DATA_BYTES), .DEV_W(DEV_W)) u_status (
    .status_i (status_byte),
    .nbytes_i (nbytes),
    .stat_o   (stat_word)
  );

  always_comb begin
    case (rd_mode)
      MODE_STATUS:            next_data = stat_word & lane_mask;
      MODE_IDENT, MODE_QUERY: next_data = packed_resp & lane_mask;
      default:                next_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= next_data;
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));
  assert_byte_mask_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_size == 2'd0) |=> rd_data[DW-1:8] == '0);
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_mode == MODE_IDLE) |=> rd_data == '0);
  assert_status_lane0_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_mode == MODE_STATUS) |=> rd_data[7:0] == $past(status_byte));
endmodule

// File: tb/flash_query_fmt_bench.sv
module flash_query_fmt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 26;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [1:0]  rd_size = '0;
  logic [1:0]  rd_mode = 2'd3;
  logic [7:0]  status_byte = 8'h80;
  logic [15:0] mfr_code = 16'h0089;
  logic [15:0] dev_code = 16'h1234;

  logic        v0, v1, v2, v3;
  logic [31:0] d0, d1, d2, d3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Byte mode of a 16-bit part, four devices in a 32-bit bank.
  flash_query_fmt #(.BANK_W(4), .DEV_W(1), .DEV_MAX_W(2)) u_flash_query_fmt (
    .clk, .rst, .rd_en, .rd_addr, .rd_size, .rd_mode, .status_byte,
    .mfr_code, .dev_code, .rd_valid(v0), .rd_data(d0));
  // One native byte-wide device.
  flash_query_fmt #(.BANK_W(1), .DEV_W(1), .DEV_MAX_W(1)) u_flash_query_fmt_narrow (
    .clk, .rst, .rd_en, .rd_addr, .rd_size, .rd_mode, .status_byte,
    .mfr_code, .dev_code, .rd_valid(v1), .rd_data(d1));
  // Two native 16-bit devices.
  flash_query_fmt #(.BANK_W(4), .DEV_W(2), .DEV_MAX_W(2)) u_flash_query_fmt_x16 (
    .clk, .rst, .rd_en, .rd_addr, .rd_size, .rd_mode, .status_byte,
    .mfr_code, .dev_code, .rd_valid(v2), .rd_data(d2));
  // 32-bit parts used 16 bits wide: unsupported narrow setup.
  flash_query_fmt #(.BANK_W(4), .DEV_W(2), .DEV_MAX_W(4)) u_flash_query_fmt_bad (
    .clk, .rst, .rd_en, .rd_addr, .rd_size, .rd_mode, .status_byte,
    .mfr_code, .dev_code, .rd_valid(v3), .rd_data(d3));

  // {sel[2], mode[2], size[2], addr[16], expected[32], req[4]}
  localparam logic [57:0] VEC [NVEC] = '{
    {2'd0, 2'd2, 2'd2, 16'h0080, 32'h51515151, 4'd5},  // R5 byte-mode fill
    {2'd0, 2'd2, 2'd2, 16'h0088, 32'h52525252, 4'd3},  // R3 shift by 3
    {2'd0, 2'd2, 2'd0, 16'h0090, 32'h00000059, 4'd10}, // R10 one byte
    {2'd0, 2'd2, 2'd1, 16'h0098, 32'h00000101, 4'd10}, // R10 two bytes
    {2'd0, 2'd2, 2'd2, 16'h0288, 32'hA5A5A5A5, 4'd4},  // R4 last entry
    {2'd0, 2'd2, 2'd2, 16'h0290, 32'h00000000, 4'd4},  // R4 beyond table
    {2'd0, 2'd2, 2'd2, 16'h0084, 32'h51515151, 4'd3},  // R3 dropped bits
    {2'd0, 2'd1, 2'd2, 16'h0000, 32'h89898989, 4'd7},  // R7 manufacturer
    {2'd0, 2'd1, 2'd2, 16'h0008, 32'h34343434, 4'd7},  // R7 device code
    {2'd0, 2'd1, 2'd2, 16'h0010, 32'h00000000, 4'd7},  // R7 lock location
    {2'd0, 2'd1, 2'd2, 16'h0800, 32'h89898989, 4'd7},  // R7 low 8 bits only
    {2'd0, 2'd0, 2'd2, 16'h0000, 32'h80808080, 4'd9},  // R9 status x4
    {2'd0, 2'd0, 2'd1, 16'h0000, 32'h00008080, 4'd9},  // R9 status x2
    {2'd0, 2'd3, 2'd2, 16'h0080, 32'h00000000, 4'd10}, // R10 idle mode
    {2'd0, 2'd2, 2'd3, 16'h0080, 32'h51515151, 4'd10}, // R10 code 3
    {2'd1, 2'd2, 2'd2, 16'h0010, 32'h01595251, 4'd8},  // R8 packing
    {2'd1, 2'd2, 2'd2, 16'h0050, 32'h0000A500, 4'd8},  // R8 across end
    {2'd1, 2'd1, 2'd1, 16'h0000, 32'h00003489, 4'd8},  // R8 ident pair
    {2'd1, 2'd0, 2'd2, 16'h0000, 32'h80808080, 4'd9},  // R9 narrow bank
    {2'd1, 2'd2, 2'd0, 16'h0012, 32'h00000059, 4'd3},  // R3 shift 0
    {2'd2, 2'd2, 2'd2, 16'h0040, 32'h00510051, 4'd6},  // R6 replicate
    {2'd2, 2'd1, 2'd2, 16'h0000, 32'h00890089, 4'd7},  // R7 16-bit code
    {2'd2, 2'd1, 2'd2, 16'h0004, 32'h12341234, 4'd7},  // R7 16-bit code
    {2'd2, 2'd0, 2'd2, 16'h0000, 32'h00800080, 4'd9},  // R9 per device
    {2'd2, 2'd0, 2'd0, 16'h0000, 32'h00000080, 4'd9},  // R9 under width
    {2'd3, 2'd2, 2'd2, 16'h0080, 32'h00000000, 4'd5}   // R5 unsupported
  };

  function automatic logic [31:0] pick_data(input logic [1:0] s);
    case (s)
      2'd0: return d0;
      2'd1: return d1;
      2'd2: return d2;
      default: return d3;
    endcase
  endfunction

  function automatic logic pick_valid(input logic [1:0] s);
    case (s)
      2'd0: return v0;
      2'd1: return v1;
      2'd2: return v2;
      default: return v3;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] m, input logic [1:0] s, input logic [15:0] a);
    @(negedge clk);
    rd_mode = m; rd_size = s; rd_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", {31'd0, v0}, 32'd0);
    check("R11 data", d0, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      do_read(VEC[i][55:54], VEC[i][53:52], VEC[i][51:36]);
      check($sformatf("R%0d vec %0d valid", VEC[i][3:0], i),
            {31'd0, pick_valid(VEC[i][57:56])}, 32'd1);
      check($sformatf("R%0d vec %0d", VEC[i][3:0], i),
            pick_data(VEC[i][57:56]), VEC[i][35:4]);
    end

    // R1: valid is a single-cycle pulse
    do_read(2'd2, 2'd2, 16'h0080);
    check("R1 pulse high", {31'd0, v0}, 32'd1);
    @(negedge clk);
    check("R1 pulse low", {31'd0, v0}, 32'd0);

    // R2: idle inputs do not disturb held data
    rd_mode = 2'd1; rd_addr = 16'h0000; status_byte = 8'h3C;
    repeat (2) @(negedge clk);
    check("R2 hold", d0, 32'h51515151);
    check("R2 valid low", {31'd0, v0}, 32'd0);

    // R9 with a different status value
    do_read(2'd0, 2'd2, 16'h0000);
    check("R9 new status", d0, 32'h3C3C3C3C);

    // R11 reset clears after activity
    rst = 1'b1;
    @(negedge clk);
    check("R11 data after reset", d0, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule